// File: doc/BRIEF.md
# Vector Instruction Sequencer for a Reconfigurable Cell

This block is the local controller of one cell in an array of small compute cells. A host fills a sixteen-slot program store with 32-bit vector instructions while the cell is idle. Each instruction carries an operation code, a repeat count and three base addresses. Once the upstream cell signals that a whole input block is present, the controller walks the program from slot 0. For every instruction it issues a run of operations to the processing element. With each issued operation it presents two read addresses for the local dual-port memory and one write address for the result stream, and all three advance by one after every operation.

The downstream ready signal gates issue. While it is low, the sequencer freezes with its remaining count and all three addresses held. A block ends on a halt instruction or after the final operation of the highest program slot ever written. The controller then returns to the idle state, pulses a one-cycle completion strobe and waits for the next block. Only the program in the store decides how the operations run, so no external schedule is needed.

Top module: `vseq_ctrl`

## Requirements
- R1: Starting one cycle after the reset is released, `ld_ready` is 1 and `pe_en` is 0. `blk_done` is 0 throughout and after reset.
- R2: The instruction word has these fields. Opcode is bits [31:28]. Bits [27:22] hold a count field N, and the instruction runs N+1 operations. The port A base is bits [21:14] and the port B base is bits [13:6]. The output base is bits [5:0], zero-extended to 8 bits. A write with `cfg_we`=1 in the idle state stores `cfg_wdata` in slot `cfg_addr`.
- R3: The unit leaves the idle state only when `blk_valid` is sampled as 1 at a clock edge. No operation is issued while `ld_ready` is 1.
- R4: During each issued operation, `pe_en` is 1, `pe_op` equals the opcode, and `addr_a`, `addr_b` and `addr_out` show the current addresses. The first operation uses the three base addresses. After each issue, all three addresses increase by 1 modulo 256.
- R5: An operation is issued only in a cycle where `dn_ready` is 1. While `dn_ready` is 0, nothing is issued, and the remaining count and the addresses hold.
- R6: Instructions run in slot order starting at slot 0. The first operation of the next instruction can issue in the cycle right after the last operation of the previous one.
- R7: Opcode 0 is a halt. It issues no operation and ends the block, whatever the value of `dn_ready`.
- R8: The block ends after the last operation of the highest slot written since reset.
- R9: In the cycle after a block ends, `ld_ready` is 1 and `blk_done` is 1. In the cycle after that, `blk_done` is 0. The next block starts again at slot 0.
- R10: Program writes made while executing are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Program store write enable |
| cfg_addr | input | 4 | Program slot to write |
| cfg_wdata | input | 32 | Instruction word to write |
| blk_valid | input | 1 | Upstream input block is complete |
| dn_ready | input | 1 | Downstream can accept a result this cycle |
| ld_ready | output | 1 | Idle: accepting program and data |
| blk_done | output | 1 | One-cycle strobe at block completion |
| pe_en | output | 1 | Operation issued this cycle |
| pe_op | output | 4 | Opcode for the processing element |
| addr_a | output | 8 | Memory port A address |
| addr_b | output | 8 | Memory port B address |
| addr_out | output | 8 | Result address |

## Verification
The assertions check properties that hold on every cycle. Nothing issues while idle or while downstream is not ready. The addresses hold across a stall. The completion strobe lasts one cycle and coincides with the idle state. Leaving idle requires `blk_valid` in the previous cycle. Only the scoreboard scenarios can show the parts that depend on what the program holds. These are the field decoding, the repeat counts, address wrap, slot order without bubbles, halt versus end-of-program termination, and writes being ignored while executing.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int OP_W   = 4;
  localparam int CNT_W  = 6;
  localparam int ADR_W  = 8;
  localparam int OBAS_W = 6;
  localparam int WORD_W = OP_W + CNT_W + 2*ADR_W + OBAS_W;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} vseq_state_e;

  // Field order is the wire format decoded by the sequencer.
  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [CNT_W-1:0]  cnt;
    logic [ADR_W-1:0]  base_a;
    logic [ADR_W-1:0]  base_b;
    logic [OBAS_W-1:0] base_o;
  } vinstr_t;

  localparam logic [OP_W-1:0] OP_HALT = '0;
endpackage

// File: rtl/vseq_cfg_mem.sv
module vseq_cfg_mem
  import vseq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx_cur,
  input  logic [IDX_W-1:0]  rd_idx_nxt,
  output vinstr_t           ins_cur,
  output vinstr_t           ins_nxt,
  output logic [IDX_W-1:0]  top_idx
);
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [IDX_W-1:0]  top_d, top_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_word;
    end
  end

  always_comb begin
    top_d = top_q;
    if (wr_en && (wr_idx > top_q)) top_d = wr_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= '0;
    else        top_q <= top_d;
  end

  assign ins_cur = vinstr_t'(slot_q[rd_idx_cur]);
  assign ins_nxt = vinstr_t'(slot_q[rd_idx_nxt]);
  assign top_idx = top_q;
endmodule

// File: rtl/vseq_opcnt.sv
module vseq_opcnt
  import vseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  vinstr_t          src,
  output logic [CNT_W-1:0] rem,
  output logic [ADR_W-1:0] a_ptr,
  output logic [ADR_W-1:0] b_ptr,
  output logic [ADR_W-1:0] o_ptr
);
  logic [CNT_W-1:0] rem_d, rem_q;
  logic [ADR_W-1:0] a_d, a_q, b_d, b_q, o_d, o_q;

  always_comb begin
    rem_d = rem_q;
    a_d   = a_q;
    b_d   = b_q;
    o_d   = o_q;
    if (load) begin
      rem_d = src.cnt;
      a_d   = src.base_a;
      b_d   = src.base_b;
      o_d   = ADR_W'(src.base_o);
    end else if (step) begin
      rem_d = rem_q - CNT_W'(1);
      a_d   = a_q + ADR_W'(1);
      b_d   = b_q + ADR_W'(1);
      o_d   = o_q + ADR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      o_q   <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      a_q   <= a_d;
      b_q   <= b_d;
      o_q   <= o_d;
    end
  end

  assign rem   = rem_q;
  assign a_ptr = a_q;
  assign b_ptr = b_q;
  assign o_ptr = o_q;
endmodule

// File: rtl/vseq_fsm.sv
module vseq_fsm
  import vseq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic             dn_ready,
  input  logic [OP_W-1:0]  cur_op,
  input  logic [CNT_W-1:0] rem,
  input  logic [IDX_W-1:0] top_idx,
  output logic [IDX_W-1:0] pc,
  output logic             running,
  output logic             issue,
  output logic             cnt_load,
  output logic             done
);
  vseq_state_e      st_d, st_q;
  logic [IDX_W-1:0] pc_d, pc_q;
  logic             done_d, done_q;
  logic             is_halt, last_op, at_top, start, advance, finish;

  always_comb begin
    is_halt = (cur_op == OP_HALT);
    last_op = (rem == '0);
    at_top  = (pc_q == top_idx);
    start   = (st_q == ST_IDLE) && blk_valid;
    issue   = (st_q == ST_RUN) && !is_halt && dn_ready;
    advance = issue && last_op && !at_top;
    finish  = (st_q == ST_RUN) && (is_halt || (issue && last_op && at_top));

    st_d   = st_q;
    pc_d   = pc_q;
    done_d = finish;
    if (start) begin
      st_d = ST_RUN;
      pc_d = '0;
    end else if (finish) begin
      st_d = ST_IDLE;
      pc_d = '0;
    end else if (advance) begin
      pc_d = pc_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      done_q <= done_d;
    end
  end

  assign pc       = pc_q;
  assign running  = (st_q == ST_RUN);
  assign cnt_load = start || advance;
  assign done     = done_q;
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              blk_valid,
  input  logic              dn_ready,
  output logic              ld_ready,
  output logic              blk_done,
  output logic              pe_en,
  output logic [OP_W-1:0]   pe_op,
  output logic [ADR_W-1:0]  addr_a,
  output logic [ADR_W-1:0]  addr_b,
  output logic [ADR_W-1:0]  addr_out
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [IDX_W-1:0] pc, top_idx, nxt_idx;
  vinstr_t          ins_cur, ins_nxt;
  logic [CNT_W-1:0] rem;
  logic             running, issue, cnt_load, done, wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Writes are honoured only while idle.
  assign wr_ok   = cfg_we && !running;
  // Second read port serves slot 0 at block start, the following slot otherwise.
  assign nxt_idx = running ? (pc + IDX_W'(1)) : '0;

  vseq_cfg_mem #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_ok), .wr_idx(cfg_addr),
    .wr_word(cfg_wdata), .rd_idx_cur(pc), .rd_idx_nxt(nxt_idx),
    .ins_cur(ins_cur), .ins_nxt(ins_nxt), .top_idx(top_idx)
  );

  vseq_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .blk_valid(blk_valid), .dn_ready(dn_ready),
    .cur_op(ins_cur.op), .rem(rem), .top_idx(top_idx), .pc(pc),
    .running(running), .issue(issue), .cnt_load(cnt_load), .done(done)
  );

  vseq_opcnt u_cnt (
    .clk(clk), .rst_n(rst_core_n), .load(cnt_load), .step(issue),
    .src(ins_nxt), .rem(rem), .a_ptr(addr_a), .b_ptr(addr_b), .o_ptr(addr_out)
  );

  assign ld_ready = !running;
  assign blk_done = done;
  assign pe_en    = issue;
  assign pe_op    = ins_cur.op;
endmodule

// File: rtl/vseq_ctrl_sva.sv
module vseq_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       blk_valid,
  input logic       dn_ready,
  input logic       ld_ready,
  input logic       blk_done,
  input logic       pe_en,
  input logic [7:0] addr_a,
  input logic [7:0] addr_b,
  input logic [7:0] addr_out
);
  p_idle_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !pe_en);

  p_start_after_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_ready) |-> $past(blk_valid));

  p_no_issue_unready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready |-> !pe_en);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ready && !dn_ready) |=>
      ($stable(addr_a) && $stable(addr_b) && $stable(addr_out)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> ld_ready);
endmodule

bind vseq_ctrl vseq_ctrl_sva u_sva (.*);

// File: tb/vseq_ctrl_bench.sv
module vseq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        blk_valid = 1'b0;
  logic        dn_ready = 1'b1;
  logic        ld_ready, blk_done, pe_en;
  logic [3:0]  pe_op;
  logic [7:0]  addr_a, addr_b, addr_out;

  int checks = 0;
  int errors = 0;
  bit toggle_rdy = 1'b0;
  bit expect_none = 1'b0;
  int cyc = 0;
  logic [27:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vseq_ctrl u_vseq_ctrl (.*);

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [5:0] n,
      input logic [7:0] a, input logic [7:0] b, input logic [5:0] o);
    return {op, n, a, b, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: predicted operations of one instruction (R2, R4).
  task automatic push_instr(input logic [3:0] op, input logic [5:0] n,
      input logic [7:0] a, input logic [7:0] b, input logic [5:0] o);
    for (int k = 0; k <= int'(n); k++)
      expq.push_back({op, a + 8'(k), b + 8'(k), {2'b00, o} + 8'(k)});
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 blk_valid = 1'b1;
    @(posedge clk); #1 blk_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    @(negedge clk);
    while (!blk_done && n < 500) begin @(negedge clk); n++; end
    chk(blk_done, {req, " end strobe"}, 32'(blk_done), 1);
    chk(ld_ready, "R9 idle with strobe", 32'(ld_ready), 1);
    chk(expq.size() == 0, {req, " all predicted ops issued"}, expq.size(), 0);
    @(negedge clk);
    chk(!blk_done, "R9 strobe one cycle", 32'(blk_done), 0);
  endtask

  // Ready pattern driver (R5 stalls).
  always @(posedge clk) begin
    #1;
    cyc++;
    if (toggle_rdy) dn_ready = (cyc % 3) != 1;
  end

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && pe_en) begin
      if (expect_none || expq.size() == 0) begin
        chk(1'b0, "R3 no issue when none predicted", 32'(pe_en), 0);
      end else begin
        logic [27:0] e;
        e = expq.pop_front();
        chk({pe_op, addr_a, addr_b, addr_out} == e, "R4 op/address",
            32'({pe_op, addr_a, addr_b, addr_out}), 32'(e));
        chk(dn_ready, "R5 issue only when ready", 32'(dn_ready), 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ld_ready, "R1 idle after reset", 32'(ld_ready), 1);
    chk(!pe_en, "R1 no issue after reset", 32'(pe_en), 0);
    chk(!blk_done, "R1 no strobe after reset", 32'(blk_done), 0);

    // Program: two vector instructions then halt (R2, R6, R7).
    wr(4'd0, mk(4'd3, 6'd2, 8'h10, 8'h20, 6'h05));
    wr(4'd1, mk(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F));
    wr(4'd2, mk(4'd0, 6'd9, 8'h00, 8'h00, 6'h00));

    // R3: nothing happens without blk_valid.
    expect_none = 1'b1;
    repeat (6) @(negedge clk);
    chk(ld_ready, "R3 stays idle without valid", 32'(ld_ready), 1);
    expect_none = 1'b0;

    // Block A: full ready, R6 back-to-back, R7 halt.
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    pulse_start();
    wait_done("R7");

    // Block B: ready toggling, R5 stall keeps count and addresses.
    toggle_rdy = 1'b1;
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    pulse_start();
    wait_done("R5");
    toggle_rdy = 1'b0;
    @(posedge clk); #1 dn_ready = 1'b1;

    // Block C: write during execution ignored (R10); check on a rerun.
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    pulse_start();
    chk(!ld_ready, "R10 write issued while running", 32'(ld_ready), 0);
    wr(4'd0, mk(4'd9, 6'd0, 8'h55, 8'h66, 6'h11));
    wait_done("R10");
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    pulse_start();
    wait_done("R10 rerun");

    // Block D: replace halt; block ends after highest written slot (R8).
    wr(4'd2, mk(4'd7, 6'd1, 8'h00, 8'h01, 6'h02));
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    push_instr(4'd7, 6'd1, 8'h00, 8'h01, 6'h02);
    pulse_start();
    wait_done("R8");

    // R9: restart from slot 0 after the end.
    push_instr(4'd3, 6'd2, 8'h10, 8'h20, 6'h05);
    push_instr(4'd5, 6'd3, 8'hFE, 8'h80, 6'h3F);
    push_instr(4'd7, 6'd1, 8'h00, 8'h01, 6'h02);
    pulse_start();
    wait_done("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule